// File: doc/BRIEF.md
# Flash Unlock-Sequence Command Decoder

This block watches the write cycles that a parallel flash-style bus has already latched. Each cycle carries an address, a data byte and a one-cycle valid strobe. The block recognises the multi-cycle command sequences that unlock the array. Each sequence opens with a fixed two-write key. Erase-class commands send that key twice. A single write of F0 is an escape that works without the key.

When a sequence completes, the block raises exactly one command pulse for one clock. The possible pulses are:
- byte program, with the target address and byte captured
- whole-chip erase
- sector erase, with the address that selects the sector
- boot-region lock
- identification-mode entry
- identification-mode exit

The block holds a sticky lock bit. While that bit is set, program and sector-erase commands aimed at the protected boot region are dropped. While the array reports that a chip erase is running, the block discards every incoming write.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset all six command pulses are low, `bootLocked` is low and the decoder is idle.
- R2: The key is data AA at low address 555, then data 55 at low address 2AA. Only address bits 11..0 take part in key and opcode matching. Bit 11 is ignored on the second key write, so AAA also matches.
- R3: The key, then A0 at 555, then any write, gives `progPulse` with `progAddr` and `progData` equal to that last write's address and byte.
- R4: The key, 80 at 555, the key again, then 10 at 555, gives `chipErasePulse`.
- R5: The same five-write prefix followed by 30 at any address gives `sectErasePulse`, with `sectAddr` equal to that address.
- R6: The five-write prefix followed by 40 at 555 gives `lockPulse` and sets `bootLocked`. Once set, `bootLocked` stays set until reset.
- R7: The key followed by 90 at 555 gives `idEnterPulse`. The key followed by F0 at 555 gives `idExitPulse`.
- R8: A write of F0 at any address gives `idExitPulse` and returns the decoder to idle from every state except the program-data write. In that state F0 is taken as the byte to program.
- R9: A write that does not continue the expected sequence returns the decoder to idle without a pulse. Third-cycle opcodes other than A0, 80, 90 and F0 give no pulse.
- R10: While `chipEraseBusy` is high, writes are discarded: they produce no pulse and leave the sequence state unchanged.
- R11: While `bootLocked` is set, a program or sector-erase target below address 0x04000 produces no pulse, and the decoder returns to idle. Targets at or above 0x04000 and chip erase still pulse.
- R12: A pulse is high during the single clock that follows the edge at which the final write was sampled. At most one pulse is high in any cycle. A cycle without an accepted write is followed by no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | One-cycle strobe marking a latched write |
| wrAddr | input | ADDR_W | Write address |
| wrData | input | 8 | Write data byte |
| chipEraseBusy | input | 1 | High while a chip erase is in progress |
| progPulse | output | 1 | Byte program command |
| progAddr | output | ADDR_W | Program target address |
| progData | output | 8 | Program data byte |
| chipErasePulse | output | 1 | Chip erase command |
| sectErasePulse | output | 1 | Sector erase command |
| sectAddr | output | ADDR_W | Address that selects the sector to erase |
| lockPulse | output | 1 | Boot-region lock command |
| idEnterPulse | output | 1 | Identification-mode entry |
| idExitPulse | output | 1 | Identification-mode exit |
| bootLocked | output | 1 | Sticky boot-region lock state |

## Verification
Every result is registered once. A command pulse, its captured address and data, and a newly set `bootLocked` all appear in the cycle after the rising edge that sampled the final write. The bench raises `wrValid` at a falling edge and drops it at the next falling edge. It reads the outputs at that second falling edge, which is exactly the one cycle in which the result is due. The bench then checks one cycle later that the pulse has gone, which covers the single-cycle width.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  localparam int CMP_W = 12;

  localparam logic [CMP_W-1:0] KEY_ADDR_A = 12'h555;
  localparam logic [10:0]      KEY_ADDR_B = 11'h2AA;

  localparam logic [7:0] KEY_DATA_A = 8'hAA;
  localparam logic [7:0] KEY_DATA_B = 8'h55;
  localparam logic [7:0] OP_PROG    = 8'hA0;
  localparam logic [7:0] OP_ERASE   = 8'h80;
  localparam logic [7:0] OP_CHIP    = 8'h10;
  localparam logic [7:0] OP_SECT    = 8'h30;
  localparam logic [7:0] OP_LOCK    = 8'h40;
  localparam logic [7:0] OP_ID_IN   = 8'h90;
  localparam logic [7:0] OP_ID_OUT  = 8'hF0;

  typedef enum logic [2:0] {
    S_IDLE,
    S_KEY1,
    S_KEY2,
    S_PROG,
    S_ERA1,
    S_ERA2,
    S_ERA3
  } seqState_t;

  typedef struct packed {
    logic capture;
    logic progGo;
    logic chipGo;
    logic sectGo;
    logic lockGo;
    logic idInGo;
    logic idOutGo;
  } cmdStrobe_t;

endpackage

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    wrValid,
  input  logic                    busy,
  input  logic [CMP_W-1:0]        lowAddr,
  input  logic [7:0]              wrData,
  input  logic                    isBootAddr,
  input  logic                    bootLocked,
  output cmdStrobe_t              strobe
);

  seqState_t stateQ;
  seqState_t stateD;
  logic      hitA;
  logic      hitB;
  logic      guarded;

  assign hitA    = (lowAddr == KEY_ADDR_A);
  assign hitB    = (lowAddr[10:0] == KEY_ADDR_B);
  assign guarded = bootLocked && isBootAddr;

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    if (wrValid && !busy) begin
      if (stateQ != S_PROG && wrData == OP_ID_OUT) begin
        strobe.idOutGo = 1'b1;
        stateD         = S_IDLE;
      end else begin
        unique case (stateQ)
          S_IDLE: begin
            if (hitA && wrData == KEY_DATA_A) stateD = S_KEY1;
          end
          S_KEY1: begin
            stateD = (hitB && wrData == KEY_DATA_B) ? S_KEY2 : S_IDLE;
          end
          S_KEY2: begin
            stateD = S_IDLE;
            if (hitA) begin
              if (wrData == OP_PROG)       stateD = S_PROG;
              else if (wrData == OP_ERASE) stateD = S_ERA1;
              else if (wrData == OP_ID_IN) strobe.idInGo = 1'b1;
            end
          end
          S_PROG: begin
            stateD = S_IDLE;
            if (!guarded) begin
              strobe.progGo  = 1'b1;
              strobe.capture = 1'b1;
            end
          end
          S_ERA1: begin
            stateD = (hitA && wrData == KEY_DATA_A) ? S_ERA2 : S_IDLE;
          end
          S_ERA2: begin
            stateD = (hitB && wrData == KEY_DATA_B) ? S_ERA3 : S_IDLE;
          end
          S_ERA3: begin
            stateD = S_IDLE;
            if (wrData == OP_SECT) begin
              if (!guarded) begin
                strobe.sectGo  = 1'b1;
                strobe.capture = 1'b1;
              end
            end else if (hitA && wrData == OP_CHIP) begin
              strobe.chipGo = 1'b1;
            end else if (hitA && wrData == OP_LOCK) begin
              strobe.lockGo = 1'b1;
            end
          end
          default: stateD = S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= S_IDLE;
    else       stateQ <= stateD;
  end

endmodule

// File: rtl/flash_cmd_dp.sv
module flash_cmd_dp
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W     = 19,
  parameter int BOOT_BYTES = 16384
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  cmdStrobe_t        strobe,
  output logic              isBootAddr,
  output logic              progPulse,
  output logic [ADDR_W-1:0] progAddr,
  output logic [7:0]        progData,
  output logic              chipErasePulse,
  output logic              sectErasePulse,
  output logic [ADDR_W-1:0] sectAddr,
  output logic              lockPulse,
  output logic              idEnterPulse,
  output logic              idExitPulse,
  output logic              bootLocked
);

  localparam logic [ADDR_W-1:0] BOOT_LIM = ADDR_W'(BOOT_BYTES);

  generate
    if (BOOT_BYTES > 0) begin : g_boot
      assign isBootAddr = (wrAddr < BOOT_LIM);
    end else begin : g_noboot
      assign isBootAddr = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      progPulse      <= 1'b0;
      chipErasePulse <= 1'b0;
      sectErasePulse <= 1'b0;
      lockPulse      <= 1'b0;
      idEnterPulse   <= 1'b0;
      idExitPulse    <= 1'b0;
      bootLocked     <= 1'b0;
      progAddr       <= '0;
      progData       <= '0;
      sectAddr       <= '0;
    end else begin
      progPulse      <= strobe.progGo;
      chipErasePulse <= strobe.chipGo;
      sectErasePulse <= strobe.sectGo;
      lockPulse      <= strobe.lockGo;
      idEnterPulse   <= strobe.idInGo;
      idExitPulse    <= strobe.idOutGo;
      if (strobe.lockGo) bootLocked <= 1'b1;
      if (strobe.capture && strobe.progGo) begin
        progAddr <= wrAddr;
        progData <= wrData;
      end
      if (strobe.capture && strobe.sectGo) sectAddr <= wrAddr;
    end
  end

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W     = 19,
  parameter int BOOT_BYTES = 16384
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic              chipEraseBusy,
  output logic              progPulse,
  output logic [ADDR_W-1:0] progAddr,
  output logic [7:0]        progData,
  output logic              chipErasePulse,
  output logic              sectErasePulse,
  output logic [ADDR_W-1:0] sectAddr,
  output logic              lockPulse,
  output logic              idEnterPulse,
  output logic              idExitPulse,
  output logic              bootLocked
);

  cmdStrobe_t strobe;
  logic       isBootAddr;

  flash_cmd_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .wrValid    (wrValid),
    .busy       (chipEraseBusy),
    .lowAddr    (wrAddr[CMP_W-1:0]),
    .wrData     (wrData),
    .isBootAddr (isBootAddr),
    .bootLocked (bootLocked),
    .strobe     (strobe)
  );

  flash_cmd_dp #(
    .ADDR_W     (ADDR_W),
    .BOOT_BYTES (BOOT_BYTES)
  ) u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .wrAddr         (wrAddr),
    .wrData         (wrData),
    .strobe         (strobe),
    .isBootAddr     (isBootAddr),
    .progPulse      (progPulse),
    .progAddr       (progAddr),
    .progData       (progData),
    .chipErasePulse (chipErasePulse),
    .sectErasePulse (sectErasePulse),
    .sectAddr       (sectAddr),
    .lockPulse      (lockPulse),
    .idEnterPulse   (idEnterPulse),
    .idExitPulse    (idExitPulse),
    .bootLocked     (bootLocked)
  );

endmodule

// File: rtl/flash_cmd_chk.sv
module flash_cmd_chk #(
  parameter int ADDR_W     = 19,
  parameter int BOOT_BYTES = 16384
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrValid,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [7:0]        wrData,
  input logic              chipEraseBusy,
  input logic              progPulse,
  input logic [ADDR_W-1:0] progAddr,
  input logic [7:0]        progData,
  input logic              chipErasePulse,
  input logic              sectErasePulse,
  input logic [ADDR_W-1:0] sectAddr,
  input logic              lockPulse,
  input logic              idEnterPulse,
  input logic              idExitPulse,
  input logic              bootLocked
);

  localparam logic [ADDR_W-1:0] BOOT_LIM = ADDR_W'(BOOT_BYTES);

  logic [5:0] pulses;
  assign pulses = {progPulse, chipErasePulse, sectErasePulse,
                   lockPulse, idEnterPulse, idExitPulse};

  p_one_pulse_r12: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(pulses));

  p_no_write_quiet_r12: assert property (@(posedge clk) disable iff (!rstN)
    !wrValid |=> (pulses == 6'b0));

  p_busy_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    chipEraseBusy |=> (pulses == 6'b0));

  p_lock_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    bootLocked |=> bootLocked);

  p_lock_sets_r6: assert property (@(posedge clk) disable iff (!rstN)
    lockPulse |-> bootLocked);

  p_boot_prog_r11: assert property (@(posedge clk) disable iff (!rstN)
    bootLocked |=> !(progPulse && progAddr < BOOT_LIM));

  p_boot_sect_r11: assert property (@(posedge clk) disable iff (!rstN)
    bootLocked |=> !(sectErasePulse && sectAddr < BOOT_LIM));

  p_prog_capture_r3: assert property (@(posedge clk) disable iff (!rstN)
    progPulse |-> (progAddr == $past(wrAddr) && progData == $past(wrData)));

endmodule

bind flash_cmd_seq flash_cmd_chk #(
  .ADDR_W     (ADDR_W),
  .BOOT_BYTES (BOOT_BYTES)
) u_chk (.*);

// File: tb/tb_flash_cmd_seq.sv
module tb_flash_cmd_seq;

  localparam int AW = 19;
  localparam logic [5:0] P_NONE = 6'b000000;
  localparam logic [5:0] P_PROG = 6'b100000;
  localparam logic [5:0] P_CHIP = 6'b010000;
  localparam logic [5:0] P_SECT = 6'b001000;
  localparam logic [5:0] P_LOCK = 6'b000100;
  localparam logic [5:0] P_IDIN = 6'b000010;
  localparam logic [5:0] P_IDEX = 6'b000001;

  logic          clk = 1'b0;
  logic          rstN;
  logic          wrValid;
  logic [AW-1:0] wrAddr;
  logic [7:0]    wrData;
  logic          chipEraseBusy;
  logic          progPulse, chipErasePulse, sectErasePulse;
  logic          lockPulse, idEnterPulse, idExitPulse, bootLocked;
  logic [AW-1:0] progAddr, sectAddr;
  logic [7:0]    progData;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  flash_cmd_seq dut (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrAddr(wrAddr),
    .wrData(wrData), .chipEraseBusy(chipEraseBusy),
    .progPulse(progPulse), .progAddr(progAddr), .progData(progData),
    .chipErasePulse(chipErasePulse), .sectErasePulse(sectErasePulse),
    .sectAddr(sectAddr), .lockPulse(lockPulse),
    .idEnterPulse(idEnterPulse), .idExitPulse(idExitPulse),
    .bootLocked(bootLocked)
  );

  function automatic logic [5:0] pv();
    return {progPulse, chipErasePulse, sectErasePulse,
            lockPulse, idEnterPulse, idExitPulse};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    wrAddr  = a;
    wrData  = d;
    wrValid = 1'b1;
    @(negedge clk);
    wrValid = 1'b0;
  endtask

  task automatic key();
    wr(19'h00555, 8'hAA);
    wr(19'h00AAA, 8'h55);
  endtask

  task automatic erasePrefix();
    key();
    wr(19'h00555, 8'h80);
    key();
  endtask

  task automatic gapQuiet(input string tag);
    @(negedge clk);
    chk(tag, {26'b0, pv()}, {26'b0, P_NONE});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R12 watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; wrValid = 1'b0; wrAddr = '0; wrData = '0;
    chipEraseBusy = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 pulses after reset", {26'b0, pv()}, {26'b0, P_NONE});
    chk("R1 lock after reset", {31'b0, bootLocked}, 32'd0);
    rstN = 1'b1;
    wr(19'h00AAA, 8'h55);
    chk("R1 idle ignores second key alone", {26'b0, pv()}, {26'b0, P_NONE});

    // Third-cycle opcode sweep: R3 R4 R7 R9 R12
    for (int d = 0; d < 256; d++) begin
      logic [5:0] e;
      key();
      wr(19'h00555, 8'(d));
      e = (d == 8'h90) ? P_IDIN : (d == 8'hF0) ? P_IDEX : P_NONE;
      chk($sformatf("R9 R7 opcode %0h", d), {26'b0, pv()}, {26'b0, e});
      if (d == 8'hA0) begin
        wr(19'h6ABCD, 8'h3C);
        chk("R3 program pulse", {26'b0, pv()}, {26'b0, P_PROG});
        chk("R3 program addr", {13'b0, progAddr}, 32'h6ABCD);
        chk("R3 program data", {24'b0, progData}, 32'h3C);
      end else if (d == 8'h80) begin
        key();
        wr(19'h00555, 8'h10);
        chk("R4 chip erase", {26'b0, pv()}, {26'b0, P_CHIP});
      end
      gapQuiet("R12 pulse lasts one cycle");
    end

    // Sixth-cycle sweep at a non-key address: R5 R8
    for (int d = 0; d < 256; d++) begin
      logic [5:0] e;
      erasePrefix();
      wr(19'h5A123, 8'(d));
      e = (d == 8'h30) ? P_SECT : (d == 8'hF0) ? P_IDEX : P_NONE;
      chk($sformatf("R5 sixth cycle %0h", d), {26'b0, pv()}, {26'b0, e});
      if (d == 8'h30)
        chk("R5 sector addr", {13'b0, sectAddr}, 32'h5A123);
    end

    // R2 address matching
    wr(19'h7F555, 8'hAA); wr(19'h01AAA, 8'h55); wr(19'h3C555, 8'h90);
    chk("R2 upper bits ignored", {26'b0, pv()}, {26'b0, P_IDIN});
    wr(19'h00555, 8'hAA); wr(19'h002AA, 8'h55); wr(19'h00555, 8'h90);
    chk("R2 2AA accepted", {26'b0, pv()}, {26'b0, P_IDIN});
    wr(19'h00555, 8'hAA); wr(19'h00AAB, 8'h55); wr(19'h00555, 8'h90);
    chk("R9 wrong key address", {26'b0, pv()}, {26'b0, P_NONE});
    wr(19'h00554, 8'hAA); wr(19'h00AAA, 8'h55); wr(19'h00555, 8'h90);
    chk("R9 wrong first address", {26'b0, pv()}, {26'b0, P_NONE});
    key(); wr(19'h00555, 8'hF0);
    chk("R7 keyed exit", {26'b0, pv()}, {26'b0, P_IDEX});

    // R8 escape
    wr(19'h00555, 8'hAA); wr(19'h00123, 8'hF0);
    chk("R8 exit from first key state", {26'b0, pv()}, {26'b0, P_IDEX});
    wr(19'h00AAA, 8'h55); wr(19'h00555, 8'h90);
    chk("R8 returned to idle", {26'b0, pv()}, {26'b0, P_NONE});
    key(); wr(19'h00555, 8'h80); wr(19'h00555, 8'hAA); wr(19'h00777, 8'hF0);
    chk("R8 exit inside erase prefix", {26'b0, pv()}, {26'b0, P_IDEX});
    wr(19'h12345, 8'hF0);
    chk("R8 exit from idle", {26'b0, pv()}, {26'b0, P_IDEX});
    key(); wr(19'h00555, 8'hA0); wr(19'h45678, 8'hF0);
    chk("R8 F0 as program data", {26'b0, pv()}, {26'b0, P_PROG});
    chk("R8 F0 data value", {24'b0, progData}, 32'hF0);

    // R10 busy
    key();
    chipEraseBusy = 1'b1;
    wr(19'h00000, 8'h12);
    chk("R10 busy junk", {26'b0, pv()}, {26'b0, P_NONE});
    wr(19'h00555, 8'hF0);
    chk("R10 busy exit ignored", {26'b0, pv()}, {26'b0, P_NONE});
    chipEraseBusy = 1'b0;
    wr(19'h00555, 8'hA0); wr(19'h20001, 8'h77);
    chk("R10 state kept across busy", {26'b0, pv()}, {26'b0, P_PROG});
    chk("R10 program addr", {13'b0, progAddr}, 32'h20001);
    chipEraseBusy = 1'b1;
    erasePrefix(); wr(19'h00555, 8'h10);
    chk("R10 chip erase while busy", {26'b0, pv()}, {26'b0, P_NONE});
    chipEraseBusy = 1'b0;

    // R6 R11 lock
    key(); wr(19'h00555, 8'hA0); wr(19'h03FFF, 8'h01);
    chk("R11 boot program before lock", {26'b0, pv()}, {26'b0, P_PROG});
    erasePrefix(); wr(19'h00555, 8'h40);
    chk("R6 lock pulse", {26'b0, pv()}, {26'b0, P_LOCK});
    chk("R6 lock set", {31'b0, bootLocked}, 32'd1);
    gapQuiet("R6 lock gap");
    key(); wr(19'h00555, 8'hA0); wr(19'h03FFF, 8'h02);
    chk("R11 boot top program blocked", {26'b0, pv()}, {26'b0, P_NONE});
    wr(19'h00555, 8'h90);
    chk("R11 idle after block", {26'b0, pv()}, {26'b0, P_NONE});
    key(); wr(19'h00555, 8'hA0); wr(19'h00000, 8'h03);
    chk("R11 boot base program blocked", {26'b0, pv()}, {26'b0, P_NONE});
    key(); wr(19'h00555, 8'hA0); wr(19'h04000, 8'h04);
    chk("R11 first open address", {26'b0, pv()}, {26'b0, P_PROG});
    chk("R11 open address value", {13'b0, progAddr}, 32'h04000);
    erasePrefix(); wr(19'h02000, 8'h30);
    chk("R11 boot sector erase blocked", {26'b0, pv()}, {26'b0, P_NONE});
    erasePrefix(); wr(19'h04000, 8'h30);
    chk("R11 open sector erase", {26'b0, pv()}, {26'b0, P_SECT});
    erasePrefix(); wr(19'h00555, 8'h10);
    chk("R11 chip erase under lock", {26'b0, pv()}, {26'b0, P_CHIP});
    chk("R6 lock sticky", {31'b0, bootLocked}, 32'd1);
    erasePrefix(); wr(19'h00555, 8'h40);
    chk("R6 relock pulse", {26'b0, pv()}, {26'b0, P_LOCK});
    gapQuiet("R12 final quiet");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule